// File: doc/BRIEF.md
# One-Time Write Lock Controller

This block decides, for a 256-byte serial memory, which writes may go ahead and whether the device answers the special lock-command slave addresses. The bus front end decodes the serial protocol and hands this block single-cycle events: a Start, a Stop, a lock-class slave address that matched the device pins (with its read/write bit), and each further received byte. The block returns a registered acknowledge decision for those events. It runs the lock command: the slave address, two dummy bytes, then a Stop. On completion it starts an internal programming window. At the end of that window it raises a sticky lock flag.

Alongside the command logic, a combinational permission path takes the address of any ordinary write and reports whether that write is allowed. The decision depends on the write-protect input level and on the lock flag. The flag stands in for a non-volatile bit. The ordinary reset does not clear it; only a dedicated test reset does.

Top module: `pwp_ctrl`

## Requirements
- R1: While `wp_pin` is 1, `wr_allow` is 0 for every address, and a lock-class address with `dev_rw` = 0 gets no acknowledge.
- R2: While `wp_pin` is 0 and `prot_set` is 0, `wr_allow` is 1 for all 256 addresses.
- R3: While `prot_set` is 1, `wr_allow` is 0 for every address below 80h, whatever the level of `wp_pin`.
- R4: While `prot_set` is 1, addresses 80h–FFh have `wr_allow` equal to the inverse of `wp_pin`.
- R5: Every acknowledge appears on `ack` for exactly one cycle, in the cycle after the event that earned it. A lock-class address with `dev_rw` = 0 earns one when `prot_set` = 0 and `wp_pin` = 0.
- R6: A lock-class address with `dev_rw` = 1 is a status query. It is acknowledged whenever `prot_set` = 0 (at either `wp_pin` level). It starts no command: a byte that follows it is not acknowledged, and `prot_set` is unchanged.
- R7: While `prot_set` is 1, no lock-class address is acknowledged, for either value of `dev_rw`.
- R8: After an acknowledged write-form address, the first two `byte_rx` events are each acknowledged. A `bus_stop` that follows them with `wp_pin` = 0 raises `busy` in the next cycle for exactly PROG_CYCLES cycles. `prot_set` becomes 1 in the cycle `busy` falls.
- R9: The command is abandoned, with no programming and `prot_set` staying 0, in any of these cases: a `bus_start` arrives before its final Stop, a Stop arrives before both dummy bytes, a third byte arrives (which is not acknowledged), or `wp_pin` is 1 at the Stop.
- R10: While `busy` is 1, all events are ignored: none earns an acknowledge, including one that arrives in the last busy cycle.
- R11: Once set, `prot_set` stays 1 through any assertion of `rst_n`; only `tst_rst_n` clears it.
- R12: While `rst_n` is held low, `ack` and `busy` are 0; `prot_set` is 0 after `tst_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of command state and timer, released synchronously |
| tst_rst_n | input | 1 | Asynchronous active-low test reset, the only way to clear the lock flag |
| wp_pin | input | 1 | Write-protect level (1 = protect everything) |
| bus_start | input | 1 | One-cycle pulse: Start condition seen |
| bus_stop | input | 1 | One-cycle pulse: Stop condition seen |
| dev_hit | input | 1 | One-cycle pulse: lock-class slave address received and pin bits matched |
| dev_rw | input | 1 | Read/write bit of that address (1 = query) |
| byte_rx | input | 1 | One-cycle pulse: a further byte received |
| wr_addr | input | 8 | Address of an ordinary write to be judged |
| ack | output | 1 | Acknowledge decision, one cycle after the event |
| busy | output | 1 | Internal programming window in progress |
| prot_set | output | 1 | Sticky lock flag |
| wr_allow | output | 1 | Write to `wr_addr` is permitted |

## Verification
The end of the programming window and a new bus event can fall in the same cycle. The bench places a status query in the final busy cycle, so the timer expires, the flag rises and the query is presented on a single clock edge. It is judged correct when the query gets no acknowledge and, one cycle later, `busy` is 0 and `prot_set` is 1; a follow-up query then confirms the flag blocks lock-class addresses. Exhaustive address sweeps at both write-protect levels are run before and after locking.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_DEV  = 3'd1,
    PS_ADR  = 3'd2,
    PS_DAT  = 3'd3,
    PS_PROG = 3'd4
  } pwp_state_e;
endpackage

// File: rtl/pwp_rst_sync.sv
module pwp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/pwp_prog_timer.sv
module pwp_prog_timer #(
  parameter int PROG_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = busy_q && (cnt_q == '0);
  assign cnt_en = start || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R8: a programming request always opens the window on the next edge
  assert_start_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/pwp_flag.sv
module pwp_flag (
  input  logic clk,
  input  logic clr_n,
  input  logic set,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = flag_q | set;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    flag_q <= 1'b0;
    else if (set)  flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R11: nothing but the test reset brings the flag down
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!clr_n)
    flag_q |=> flag_q);
endmodule

// File: rtl/pwp_guard.sv
module pwp_guard #(
  parameter int ADDR_W = 8
) (
  input  logic              wp,
  input  logic              flag,
  input  logic [ADDR_W-1:0] addr,
  output logic              allow
);
  localparam logic [ADDR_W-1:0] LOCK_END = ADDR_W'(1) << (ADDR_W - 1);

  logic in_locked_half;

  always_comb begin
    in_locked_half = (addr < LOCK_END);
    allow = !wp && !(flag && in_locked_half);
  end
endmodule

// File: rtl/pwp_seq.sv
module pwp_seq
  import pwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic dev_hit,
  input  logic dev_rw,
  input  logic byte_rx,
  input  logic wp,
  input  logic flag,
  input  logic prog_done,
  output logic ack,
  output logic prog_go
);
  pwp_state_e st_q, st_d;
  logic       ack_q, ack_d;

  always_comb begin
    st_d    = st_q;
    ack_d   = 1'b0;
    prog_go = 1'b0;
    if (st_q == PS_PROG) begin
      if (prog_done) st_d = PS_IDLE;
    end else begin
      if (bus_start) begin
        st_d = PS_IDLE;
      end else begin
        case (st_q)
          PS_DEV: begin
            if (byte_rx) begin
              ack_d = 1'b1;
              st_d  = PS_ADR;
            end else if (bus_stop) begin
              st_d = PS_IDLE;
            end
          end
          PS_ADR: begin
            if (byte_rx) begin
              ack_d = 1'b1;
              st_d  = PS_DAT;
            end else if (bus_stop) begin
              st_d = PS_IDLE;
            end
          end
          PS_DAT: begin
            if (bus_stop) begin
              if (!wp) begin
                prog_go = 1'b1;
                st_d    = PS_PROG;
              end else begin
                st_d = PS_IDLE;
              end
            end else if (byte_rx) begin
              st_d = PS_IDLE;
            end
          end
          default: st_d = PS_IDLE;
        endcase
      end
      if (dev_hit) begin
        prog_go = 1'b0;
        st_d    = PS_IDLE;
        if (!flag) begin
          if (dev_rw) begin
            ack_d = 1'b1;
          end else if (!wp) begin
            ack_d = 1'b1;
            st_d  = PS_DEV;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  assign ack = ack_q;

  // R1: write-form lock address under write protect is never acknowledged
  assert_wp_blocks_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && !dev_rw && wp) |=> !ack_q);
  // R10: nothing is acknowledged while programming
  assert_prog_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_PROG) |=> !ack_q);
  // R7: a set flag silences the lock-class addresses
  assert_flag_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && dev_hit) |=> !ack_q);
  // R5: an acknowledge lasts a single cycle here
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !dev_hit && !byte_rx) |=> !ack_q);
endmodule

// File: rtl/pwp_ctrl.sv
module pwp_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_rst_n,
  input  logic              wp_pin,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              dev_hit,
  input  logic              dev_rw,
  input  logic              byte_rx,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ack,
  output logic              busy,
  output logic              prot_set,
  output logic              wr_allow
);
  localparam logic [ADDR_W-1:0] LOCK_END = ADDR_W'(1) << (ADDR_W - 1);

  logic rst_s_n;
  logic tst_s_n;
  logic prog_go;
  logic prog_done;

  pwp_rst_sync u_rsync_main (.clk(clk), .arst_n(rst_n),     .srst_n(rst_s_n));
  pwp_rst_sync u_rsync_test (.clk(clk), .arst_n(tst_rst_n), .srst_n(tst_s_n));

  pwp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .dev_hit   (dev_hit),
    .dev_rw    (dev_rw),
    .byte_rx   (byte_rx),
    .wp        (wp_pin),
    .flag      (prot_set),
    .prog_done (prog_done),
    .ack       (ack),
    .prog_go   (prog_go)
  );

  pwp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (prog_go),
    .busy  (busy),
    .done  (prog_done)
  );

  pwp_flag u_flag (
    .clk   (clk),
    .clr_n (tst_s_n),
    .set   (prog_done),
    .flag  (prot_set)
  );

  pwp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .wp    (wp_pin),
    .flag  (prot_set),
    .addr  (wr_addr),
    .allow (wr_allow)
  );

  // R3: lower half stays locked once the flag is up
  assert_lower_locked_R3: assert property (@(posedge clk) disable iff (!tst_s_n)
    (prot_set && (wr_addr < LOCK_END)) |-> !wr_allow);
  // R8: the flag only rises as the programming window closes
  assert_set_after_prog_R8: assert property (@(posedge clk) disable iff (!rst_s_n || !tst_s_n)
    $rose(prot_set) |-> ($past(busy) && !busy));
  // R9: a window opens only from a Stop seen with protect low
  assert_prog_needs_stop_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past(bus_stop && !wp_pin));
endmodule

// File: tb/tb_pwp_ctrl.sv
module tb_pwp_ctrl;
  localparam int PROG = 12;

  logic       clk = 1'b0;
  logic       rst_n, tst_rst_n, wp_pin;
  logic       bus_start, bus_stop, dev_hit, dev_rw, byte_rx;
  logic [7:0] wr_addr;
  logic       ack, busy, prot_set, wr_allow;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  pwp_ctrl #(.ADDR_W(8), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .tst_rst_n(tst_rst_n), .wp_pin(wp_pin),
    .bus_start(bus_start), .bus_stop(bus_stop), .dev_hit(dev_hit),
    .dev_rw(dev_rw), .byte_rx(byte_rx), .wr_addr(wr_addr),
    .ack(ack), .busy(busy), .prot_set(prot_set), .wr_allow(wr_allow)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  // each event task starts and ends at a falling edge; ack is valid on return
  task automatic ev_start(); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0; endtask
  task automatic ev_stop();  bus_stop  = 1'b1; @(negedge clk); bus_stop  = 1'b0; endtask
  task automatic ev_byte();  byte_rx   = 1'b1; @(negedge clk); byte_rx   = 1'b0; endtask
  task automatic ev_dev(input logic rw);
    dev_hit = 1'b1; dev_rw = rw; @(negedge clk); dev_hit = 1'b0; dev_rw = 1'b0;
  endtask

  function automatic logic exp_allow(input int a, input logic wp, input logic fl);
    return !wp && (!fl || a >= 128);
  endfunction

  task automatic sweep(input logic fl);
    for (int w = 0; w < 2; w++) begin
      wp_pin = w[0];
      for (int a = 0; a < 256; a++) begin
        wr_addr = a[7:0];
        #1;
        if (fl) begin
          if (a < 128) chk("R3", $sformatf("allow a=%0d wp=%0d", a, w), wr_allow, 1'b0);
          else         chk("R4", $sformatf("allow a=%0d wp=%0d", a, w), wr_allow, exp_allow(a, w[0], fl));
        end else begin
          if (w == 1)  chk("R1", $sformatf("allow a=%0d", a), wr_allow, 1'b0);
          else         chk("R2", $sformatf("allow a=%0d", a), wr_allow, exp_allow(a, w[0], fl));
        end
      end
    end
    wp_pin = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0; tst_rst_n = 1'b0; wp_pin = 1'b0;
    bus_start = 1'b0; bus_stop = 1'b0; dev_hit = 1'b0; dev_rw = 1'b0; byte_rx = 1'b0;
    wr_addr = '0;
    repeat (4) @(negedge clk);
    chk("R12", "ack in reset", ack, 1'b0);
    chk("R12", "busy in reset", busy, 1'b0);
    chk("R12", "flag after test reset", prot_set, 1'b0);
    rst_n = 1'b1; tst_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    sweep(1'b0);

    // R1: write-form lock address under protect
    wp_pin = 1'b1; ev_dev(1'b0);
    chk("R1", "ack write-form wp=1", ack, 1'b0);
    // R6: query answered even with protect high, and starts nothing
    ev_dev(1'b1);
    chk("R6", "ack query wp=1", ack, 1'b1);
    wp_pin = 1'b0;
    ev_byte();
    chk("R6", "byte after query", ack, 1'b0);
    chk("R6", "flag after query", prot_set, 1'b0);

    // R9: Start before the final Stop abandons
    ev_dev(1'b0); chk("R5", "ack write-form", ack, 1'b1);
    @(negedge clk); chk("R5", "ack one cycle only", ack, 1'b0);
    ev_byte(); chk("R8", "ack dummy addr", ack, 1'b1);
    ev_byte(); chk("R8", "ack dummy data", ack, 1'b1);
    ev_start(); ev_stop();
    chk("R9", "busy after abandoned start", busy, 1'b0);
    // R9: early Stop
    ev_dev(1'b0); ev_byte(); ev_stop();
    chk("R9", "busy after early stop", busy, 1'b0);
    // R9: protect high at Stop
    ev_dev(1'b0); ev_byte(); ev_byte();
    wp_pin = 1'b1; ev_stop(); wp_pin = 1'b0;
    chk("R9", "busy after wp stop", busy, 1'b0);
    // R9: third byte
    ev_dev(1'b0); ev_byte(); ev_byte(); ev_byte();
    chk("R9", "third byte ack", ack, 1'b0);
    ev_stop();
    chk("R9", "busy after third byte", busy, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9", "flag after aborts", prot_set, 1'b0);

    // R8: full command, R10 events during the window
    ev_dev(1'b0); chk("R8", "ack cmd addr", ack, 1'b1);
    ev_byte();    chk("R8", "ack byte1", ack, 1'b1);
    ev_byte();    chk("R8", "ack byte2", ack, 1'b1);
    ev_stop();
    cnt = 0;
    while (busy === 1'b1 && cnt < PROG + 4) begin
      cnt++;
      chk("R10", $sformatf("ack in busy cycle %0d", cnt), ack, 1'b0);
      chk("R8", $sformatf("flag during busy %0d", cnt), prot_set, 1'b0);
      byte_rx = 1'b0; dev_hit = 1'b0; dev_rw = 1'b0; bus_start = 1'b0;
      if (cnt == 2) byte_rx = 1'b1;
      if (cnt == 4) bus_start = 1'b1;
      if (cnt == PROG) begin dev_hit = 1'b1; dev_rw = 1'b1; end
      @(negedge clk);
    end
    byte_rx = 1'b0; dev_hit = 1'b0; dev_rw = 1'b0; bus_start = 1'b0;
    checks++;
    if (cnt != PROG) begin
      failures++;
      $display("FAIL R8 busy length actual=%0d expected=%0d", cnt, PROG);
    end
    chk("R10", "query in last busy cycle", ack, 1'b0);
    chk("R8", "flag after window", prot_set, 1'b1);

    // R7
    ev_dev(1'b1); chk("R7", "query after lock", ack, 1'b0);
    ev_dev(1'b0); chk("R7", "write-form after lock", ack, 1'b0);

    sweep(1'b1);

    // R11: ordinary reset keeps the flag
    rst_n = 1'b0; @(negedge clk);
    chk("R12", "ack in reset", ack, 1'b0);
    chk("R12", "busy in reset", busy, 1'b0);
    rst_n = 1'b1; repeat (4) @(negedge clk);
    chk("R11", "flag after rst_n", prot_set, 1'b1);
    tst_rst_n = 1'b0; @(negedge clk); tst_rst_n = 1'b1; repeat (4) @(negedge clk);
    chk("R11", "flag after test reset", prot_set, 1'b0);
    ev_dev(1'b1); chk("R11", "query after test reset", ack, 1'b1);
    wr_addr = 8'h10; #1;
    chk("R11", "lower half writable again", wr_allow, 1'b1);

    finish_run();
  end
endmodule